// File: doc/BRIEF.md
# Open-Drain Port Controller with Standby Pin Control

This block controls a small group of general-purpose pins whose drivers behave as open drain. A data register holds one bit per pin. A 0 in that register pulls the pin low. A 1 releases the pin, so an external pull-up or another function sets the level. A released pin can be handed to an LCD segment driver. The upper pins can also carry a UART transmit signal. The pad, the LCD controller and the UART sit outside the block and appear here only as select and data inputs.

Reading the register returns the live pin levels. The exception is a pin assigned to LCD segment output, where the read returns the latch bit. Reset sets every latch bit to 1, so the whole port comes up released.

On entry to a deep standby mode, a designate bit chosen at entry decides what happens to the port. With the bit set, every driver is switched off and the input path is forced to 0, so floating pins cannot cause leakage. With the bit clear, the port keeps its normal behaviour.

Top module: `odport_ctrl`

## Requirements
- R1: When `wr_en` is 1 at a rising clock edge, the latch takes `wr_data`. With every pin assigned to LCD output, `rd_data` then equals the written value.
- R2: A pin not in standby float, not LCD-selected and not carrying UART is in port mode. If its latch bit is 0, the pin has `pad_oe`=1 and `pad_out`=0. If its latch bit is 1, the pin has `pad_oe`=0.
- R3: A pin with its `lcd_sel` bit at 1 is never driven by the block (`pad_oe`=0), whatever its latch bit or UART enable.
- R4: While `rst_n` is low and after it is released, every latch bit is 1, no pin is driven, and the standby float is off.
- R5: Bit k of `uart_en` and `uart_tx` belongs to pin NUM_PINS-UART_PINS+k (pins 4 and 5 by default). That pin drives `pad_oe`=1 and `pad_out`=`uart_tx[k]` when three conditions hold: `uart_en[k]` is 1, its latch bit is 1, and it is not LCD-selected. If its latch bit is 0, port mode drives it low instead. Lower pins have no UART source.
- R6: Outside standby float, the `rd_data` bit of a pin that is not LCD-selected equals its `pad_in` bit, and the bit of an LCD-selected pin equals its latch bit.
- R7: Standby float starts after the first rising edge at which `stby_req` is sampled 1 while `stby_float_en` is 1. It lasts until an edge samples `stby_req` at 0. While it lasts, `pad_oe`, `in_gated` and `rd_data` are all zero, and writes still update the latch.
- R8: Changes of `stby_float_en` while `stby_req` stays 1 have no effect until the next standby entry.
- R9: Standby entered with `stby_float_en` at 0 leaves all pin outputs exactly as in normal operation.
- R10: Outside standby float, `in_gated` equals `pad_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | NUM_PINS | Data register write value |
| rd_data | output | NUM_PINS | Data register read value (pin levels or latch) |
| lcd_sel | input | NUM_PINS | Per-pin LCD segment output select |
| uart_en | input | UART_PINS | UART output enable for the upper pins |
| uart_tx | input | UART_PINS | UART transmit value for the upper pins |
| stby_req | input | 1 | Stop or watch mode indication |
| stby_float_en | input | 1 | Float pins during standby when set at entry |
| pad_in | input | NUM_PINS | Pin levels from the pads |
| pad_oe | output | NUM_PINS | Per-pin driver enable |
| pad_out | output | NUM_PINS | Per-pin driven value |
| in_gated | output | NUM_PINS | Input path after standby fixing |

## Verification
The bench builds the block with its defaults: six pins, the top two of which carry UART. With this size, all 64 latch values can be swept against all 64 LCD select patterns and all four UART enable combinations. The external pin level is modelled as a pull-up that an external low pattern can override, and that pattern varies with the sweep, so every read path is exercised. Directed sequences cover entry to standby with the designate bit set and clear, changes of that bit during standby, writes while floating, and exit.

// File: rtl/odport_pkg.sv
package odport_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PORT = 2'd1,
        SRC_UART = 2'd2
    } pin_src_e;

    typedef struct packed {
        logic in_stby;
        logic floating;
    } stby_state_t;

endpackage

// File: rtl/odport_latch.sv
module odport_latch #(
    parameter int NUM_PINS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [NUM_PINS-1:0] wr_data,
    output logic [NUM_PINS-1:0] latch_q
);
    logic [NUM_PINS-1:0] latch_d;

    always_comb begin
        latch_d = latch_q;
        if (wr_en) begin
            latch_d = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '1;
        end else begin
            latch_q <= latch_d;
        end
    end
endmodule

// File: rtl/odport_stby.sv
module odport_stby
    import odport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stby_req,
    input  logic stby_float_en,
    output logic in_stby,
    output logic floating
);
    stby_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.in_stby = stby_req;
        if (!stby_req) begin
            st_d.floating = 1'b0;
        end else if (!st_q.in_stby) begin
            st_d.floating = stby_float_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_stby  = st_q.in_stby;
    assign floating = st_q.floating;
endmodule

// File: rtl/odport_pin.sv
module odport_pin
    import odport_pkg::*;
#(
    parameter bit HAS_UART = 1'b0
) (
    input  logic latch_bit,
    input  logic lcd_sel,
    input  logic uart_en,
    input  logic uart_tx,
    input  logic floating,
    input  logic pad_in,
    output logic pad_oe,
    output logic pad_out,
    output logic in_gated,
    output logic rd_bit
);
    pin_src_e src;
    logic     uart_act;

    assign uart_act = HAS_UART && uart_en && latch_bit && !lcd_sel;

    always_comb begin
        src = SRC_NONE;
        if (!floating && !lcd_sel) begin
            if (uart_act) begin
                src = SRC_UART;
            end else if (!latch_bit) begin
                src = SRC_PORT;
            end
        end
    end

    always_comb begin
        pad_oe  = 1'b0;
        pad_out = 1'b0;
        case (src)
            SRC_UART: begin
                pad_oe  = 1'b1;
                pad_out = uart_tx;
            end
            SRC_PORT: begin
                pad_oe  = 1'b1;
                pad_out = 1'b0;
            end
            default: begin
                pad_oe  = 1'b0;
                pad_out = 1'b0;
            end
        endcase
    end

    always_comb begin
        in_gated = floating ? 1'b0 : pad_in;
        if (floating) begin
            rd_bit = 1'b0;
        end else if (lcd_sel) begin
            rd_bit = latch_bit;
        end else begin
            rd_bit = pad_in;
        end
    end
endmodule

// File: rtl/odport_ctrl.sv
module odport_ctrl #(
    parameter int NUM_PINS  = 6,
    parameter int UART_PINS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NUM_PINS-1:0]  wr_data,
    output logic [NUM_PINS-1:0]  rd_data,
    input  logic [NUM_PINS-1:0]  lcd_sel,
    input  logic [UART_PINS-1:0] uart_en,
    input  logic [UART_PINS-1:0] uart_tx,
    input  logic                 stby_req,
    input  logic                 stby_float_en,
    input  logic [NUM_PINS-1:0]  pad_in,
    output logic [NUM_PINS-1:0]  pad_oe,
    output logic [NUM_PINS-1:0]  pad_out,
    output logic [NUM_PINS-1:0]  in_gated
);
    localparam int UART_BASE = NUM_PINS - UART_PINS;

    logic [NUM_PINS-1:0] latch_q;
    logic                in_stby;
    logic                floating;

    odport_latch #(.NUM_PINS(NUM_PINS)) latch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .latch_q (latch_q)
    );

    odport_stby stby_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .stby_req      (stby_req),
        .stby_float_en (stby_float_en),
        .in_stby       (in_stby),
        .floating      (floating)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        if (i >= UART_BASE) begin : g_uart
            odport_pin #(.HAS_UART(1'b1)) pin_i (
                .latch_bit (latch_q[i]),
                .lcd_sel   (lcd_sel[i]),
                .uart_en   (uart_en[i-UART_BASE]),
                .uart_tx   (uart_tx[i-UART_BASE]),
                .floating  (floating),
                .pad_in    (pad_in[i]),
                .pad_oe    (pad_oe[i]),
                .pad_out   (pad_out[i]),
                .in_gated  (in_gated[i]),
                .rd_bit    (rd_data[i])
            );
        end else begin : g_plain
            odport_pin #(.HAS_UART(1'b0)) pin_i (
                .latch_bit (latch_q[i]),
                .lcd_sel   (lcd_sel[i]),
                .uart_en   (1'b0),
                .uart_tx   (1'b0),
                .floating  (floating),
                .pad_in    (pad_in[i]),
                .pad_oe    (pad_oe[i]),
                .pad_out   (pad_out[i]),
                .in_gated  (in_gated[i]),
                .rd_bit    (rd_data[i])
            );
        end
    end
endmodule

// File: rtl/odport_chk.sv
module odport_chk #(
    parameter int NUM_PINS  = 6,
    parameter int UART_PINS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [NUM_PINS-1:0] wr_data,
    input logic [NUM_PINS-1:0] rd_data,
    input logic [NUM_PINS-1:0] lcd_sel,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] in_gated,
    input logic [NUM_PINS-1:0] latch_q,
    input logic                in_stby,
    input logic                stby_req,
    input logic                floating
);
    localparam int UART_BASE = NUM_PINS - UART_PINS;

    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> latch_q == $past(wr_data)); // R1

    AST_LCD_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_sel & pad_oe) == '0); // R3

    AST_FLOAT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        floating |-> (pad_oe == '0 && in_gated == '0 && rd_data == '0)); // R7

    AST_FLOAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stby && stby_req) |=> $stable(floating)); // R8

    AST_FLOAT_NEEDS_STBY: assert property (@(posedge clk) disable iff (!rst_n)
        floating |-> in_stby); // R7

    for (genvar i = 0; i < UART_BASE; i++) begin : g_low
        AST_LOW_PIN_PORT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            pad_oe[i] |-> (!latch_q[i] && !pad_out[i])); // R2
    end
endmodule

bind odport_ctrl odport_chk #(.NUM_PINS(NUM_PINS), .UART_PINS(UART_PINS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .lcd_sel  (lcd_sel),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out),
    .in_gated (in_gated),
    .latch_q  (latch_q),
    .in_stby  (in_stby),
    .stby_req (stby_req),
    .floating (floating)
);

// File: tb/odport_ctrl_tb.sv
module odport_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 6;
    localparam int NU = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [NP-1:0] wr_data = '0;
    logic [NP-1:0] rd_data;
    logic [NP-1:0] lcd_sel = '0;
    logic [NU-1:0] uart_en = '0;
    logic [NU-1:0] uart_tx = '0;
    logic          stby_req = 1'b0;
    logic          stby_float_en = 1'b0;
    logic [NP-1:0] pad_in;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] in_gated;
    logic [NP-1:0] ext_low = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // pull-up, overridden low by external pattern when released
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ~ext_low);

    odport_ctrl #(.NUM_PINS(NP), .UART_PINS(NU)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .lcd_sel(lcd_sel), .uart_en(uart_en),
        .uart_tx(uart_tx), .stby_req(stby_req), .stby_float_en(stby_float_en),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .in_gated(in_gated)
    );

    task automatic check(input string req, input string what,
                         input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    function automatic void model(input logic [NP-1:0] lat, input logic [NP-1:0] lcd,
                                  input logic [NU-1:0] ue, input logic [NU-1:0] ut,
                                  input bit flt, input logic [NP-1:0] xl,
                                  output logic [NP-1:0] oe, output logic [NP-1:0] o,
                                  output logic [NP-1:0] rd, output logic [NP-1:0] ig);
        logic [NP-1:0] lvl;
        oe = '0;
        o  = '0;
        for (int i = 0; i < NP; i++) begin
            if (!flt && !lcd[i]) begin
                if (i >= NP-NU && ue[i-(NP-NU)] && lat[i]) begin
                    oe[i] = 1'b1;
                    o[i]  = ut[i-(NP-NU)];
                end else if (!lat[i]) begin
                    oe[i] = 1'b1;
                end
            end
        end
        lvl = (oe & o) | (~oe & ~xl);
        rd  = flt ? '0 : ((lcd & lat) | (~lcd & lvl));
        ig  = flt ? '0 : lvl;
    endfunction

    task automatic check_all(input string req, input logic [NP-1:0] lat, input bit flt);
        logic [NP-1:0] eo, ev, er, eg;
        model(lat, lcd_sel, uart_en, uart_tx, flt, ext_low, eo, ev, er, eg);
        check(req, "pad_oe", pad_oe, eo);
        check(req, "pad_out", pad_out, ev);
        check({req, " R6"}, "rd_data", rd_data, er);
        check({req, " R10"}, "in_gated", in_gated, eg);
    endtask

    task automatic write_reg(input logic [NP-1:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NP-1:0] lat;
        repeat (3) @(negedge clk);
        // R4: state during reset
        check("R4", "pad_oe in reset", pad_oe, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4", "pad_oe after reset", pad_oe, '0);
        check("R4", "rd_data after reset", rd_data, 6'h3F);
        lcd_sel = '1;
        #1;
        check("R4", "latch after reset", rd_data, 6'h3F);
        lcd_sel = '0;

        // near-exhaustive sweep: latch x lcd x uart enable
        for (int w = 0; w < 64; w++) begin
            lat = NP'(w);
            write_reg(lat);
            lcd_sel = '1;
            #1;
            check("R1 R3", "rd_data after write", rd_data, lat);
            for (int l = 0; l < 64; l++) begin
                for (int u = 0; u < 4; u++) begin
                    lcd_sel = NP'(l);
                    uart_en = NU'(u);
                    uart_tx = NU'(u) ^ lat[NP-1:NP-NU] ^ NU'(l);
                    ext_low = NP'(w ^ (l * 5) ^ u);
                    #1;
                    check_all("R2 R3 R5", lat, 1'b0);
                end
            end
        end
        lcd_sel = '0;
        uart_en = '0;
        ext_low = '0;

        // standby with designate clear keeps normal behaviour
        lat = 6'b101010;
        write_reg(lat);
        stby_float_en = 1'b0;
        stby_req = 1'b1;
        @(negedge clk);
        check_all("R9", lat, 1'b0);
        stby_float_en = 1'b1;
        @(negedge clk);
        check_all("R8 R9", lat, 1'b0);
        stby_req = 1'b0;
        @(negedge clk);

        // float entry, one cycle after the sampling edge
        stby_float_en = 1'b1;
        stby_req = 1'b1;
        ext_low = 6'b001100;
        #1;
        check_all("R7 before edge", lat, 1'b0);
        @(negedge clk);
        check_all("R7", lat, 1'b1);
        stby_float_en = 1'b0;
        @(negedge clk);
        check_all("R8", lat, 1'b1);
        lcd_sel = 6'b000011;
        uart_en = 2'b11;
        uart_tx = 2'b11;
        write_reg(6'b000000);
        check_all("R7 write in float", 6'b000000, 1'b1);
        lcd_sel = '0;
        uart_en = '0;
        stby_req = 1'b0;
        @(negedge clk);
        check_all("R7 exit", 6'b000000, 1'b0);
        check("R7", "pad_oe after exit", pad_oe, 6'h3F);
        ext_low = '0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule